// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines two pieces of context. A field of low branch-address bits picks a row of a counter table. The outcomes of the most recent branches, kept in a small global shift register, pick one saturating counter within that row. The upper bit of the selected counter is the prediction.

The fetch side presents a branch address and receives a combinational taken/not-taken answer. It also receives the history value used to form that answer. The execute side later returns the same address, the history value it was given and the real outcome. That trains exactly one counter and shifts the outcome into the global history. A prediction and a resolve may occur in the same cycle. In that case the prediction reflects the state before the update.

Top module: `corr_predictor`

## Requirements
- R1: Synchronous active-high reset sets every counter to the weakly-not-taken value 01 (for 2-bit counters) and clears the history to zero, so after reset every address predicts not taken and `pred_hist` reads 0.
- R2: `pred_taken` is the upper bit of the counter at row `pred_pc[5:2]` (defaults: row field starts at bit 2 and is 4 bits wide) and column equal to the current global history, and it is valid in the same cycle.
- R3: `pred_hist` always shows the current global history register, where bit 0 is the newest outcome (1 = taken, 0 = not taken).
- R4: On a cycle with `res_valid` high, the history shifts left by one at the clock edge, with `res_taken` entering at bit 0 and the oldest bit dropped.
- R5: A resolve changes only the counter at row `res_pc[5:2]`, column `res_hist`; all other counters keep their values.
- R6: The selected counter increments on a taken outcome and decrements on a not-taken outcome, and it saturates at 3 and at 0.
- R7: A counter in a strong state (00 or 11) needs two consecutive opposite outcomes before its prediction flips.
- R8: Training uses the `res_hist` value carried with the resolve request, not the history register's value at resolve time.
- R9: With `res_valid` low, neither the counters nor the history change.
- R10: Address bits outside the row field (bits 1:0 and bits 31:6) have no effect on which counter is read or trained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 2 | Global history used for this prediction |
| res_valid | input | 1 | Resolve request strobe |
| res_pc | input | 32 | Address of the resolved branch |
| res_hist | input | 2 | History captured when the branch was predicted |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Directed sequences first drive the same branch address under each history value. This shows that the four counters in a row are trained independently and that history, not address alone, steers the answer. Runs of identical outcomes push a counter to both saturation limits and then back, which separates a two-bit hysteresis counter from a one-bit flip and from a counter that wraps. Resolves that carry a stale history value show whether training follows the carried history or the live register. A long random mix of addresses with scrambled high and low bits, random outcomes and occasional idle cycles then compares every prediction and history value against a reference model.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

    localparam int DEF_PC_W      = 32;
    localparam int DEF_ROW_LSB   = 2;
    localparam int DEF_ROW_BITS  = 4;
    localparam int DEF_HIST_BITS = 2;
    localparam int DEF_CTR_BITS  = 2;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // Reset value of a counter: just below the taken threshold.
    function automatic int weak_nt_value(input int bits);
        return (1 << (bits - 1)) - 1;
    endfunction

endpackage

// File: rtl/corr_ghist.sv
module corr_ghist #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_shifted;

    generate
        if (HIST_BITS == 1) begin : g_one
            assign hist_shifted = shift_bit;
        end else begin : g_many
            assign hist_shifted = {hist_q[HIST_BITS-2:0], shift_bit};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_shifted;
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/corr_ctr_update.sv
module corr_ctr_update
    import corr_pred_pkg::*;
#(
    parameter int CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  dir_e                outcome,
    output logic [CTR_BITS-1:0] nxt
);

    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
    localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

    always_comb begin
        nxt = cur;
        if (outcome == DIR_TAKEN) begin
            if (cur != CTR_MAX) nxt = cur + 1'b1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 1'b1;
        end
    end

endmodule

// File: rtl/corr_ctr_table.sv
module corr_ctr_table
    import corr_pred_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CTR_BITS-1:0] rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic [CTR_BITS-1:0] wr_old,
    input  logic [CTR_BITS-1:0] wr_data
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CTR_BITS-1:0] RESET_VAL = CTR_BITS'(weak_nt_value(CTR_BITS));

    logic [CTR_BITS-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= RESET_VAL;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
    assign wr_old  = mem[wr_idx];

    // R6: a training write moves the counter by at most one step.
    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((int'(wr_data) - int'(wr_old)) <= 1 &&
                   (int'(wr_old) - int'(wr_data)) <= 1));

    // R5: the written value lands in the addressed entry.
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
    import corr_pred_pkg::*;
#(
    parameter int PC_W      = DEF_PC_W,
    parameter int ROW_LSB   = DEF_ROW_LSB,
    parameter int ROW_BITS  = DEF_ROW_BITS,
    parameter int HIST_BITS = DEF_HIST_BITS,
    parameter int CTR_BITS  = DEF_CTR_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PC_W-1:0]      pred_pc,
    output logic                 pred_taken,
    output logic [HIST_BITS-1:0] pred_hist,
    input  logic                 res_valid,
    input  logic [PC_W-1:0]      res_pc,
    input  logic [HIST_BITS-1:0] res_hist,
    input  logic                 res_taken
);

    localparam int IDX_W = ROW_BITS + HIST_BITS;

    logic [HIST_BITS-1:0] ghist;
    logic [ROW_BITS-1:0]  pred_row;
    logic [ROW_BITS-1:0]  res_row;
    logic [IDX_W-1:0]     rd_idx;
    logic [IDX_W-1:0]     wr_idx;
    logic [CTR_BITS-1:0]  rd_ctr;
    logic [CTR_BITS-1:0]  old_ctr;
    logic [CTR_BITS-1:0]  new_ctr;
    dir_e                 outcome;
    logic                 unused_pc_bits;

    assign pred_row = pred_pc[ROW_LSB +: ROW_BITS];
    assign res_row  = res_pc[ROW_LSB +: ROW_BITS];
    assign rd_idx   = {pred_row, ghist};
    assign wr_idx   = {res_row, res_hist};
    assign outcome  = res_taken ? DIR_TAKEN : DIR_NOT_TAKEN;
    assign unused_pc_bits = ^pred_pc ^ ^res_pc;

    corr_ghist #(.HIST_BITS(HIST_BITS)) u_ghist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist      (ghist)
    );

    corr_ctr_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_data (rd_ctr),
        .wr_en   (res_valid),
        .wr_idx  (wr_idx),
        .wr_old  (old_ctr),
        .wr_data (new_ctr)
    );

    corr_ctr_update #(.CTR_BITS(CTR_BITS)) u_update (
        .cur     (old_ctr),
        .outcome (outcome),
        .nxt     (new_ctr)
    );

    assign pred_taken = rd_ctr[CTR_BITS-1];
    assign pred_hist  = ghist;

    // R1: history is clear in the cycle after reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pred_hist == '0));

    // R4: the newest outcome appears at bit 0 after a resolve.
    assert_newest_bit_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (pred_hist[0] == $past(res_taken)));

    // R9: an idle cycle leaves the history untouched.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(pred_hist));

    generate
        if (HIST_BITS > 1) begin : g_age_chk
            // R4: older bits move up one place.
            assert_age_shift_R4: assert property (@(posedge clk) disable iff (rst)
                res_valid |=> (pred_hist[HIST_BITS-1:1] == $past(pred_hist[HIST_BITS-2:0])));
        end
    endgenerate

endmodule

// File: tb/corr_predictor_test.sv
`timescale 1ns/1ps
module corr_predictor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic [1:0]  res_hist = '0;
    logic        res_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int model_ctr [64];
    int model_hist;

    always #4 clk = ~clk;

    corr_predictor uut (
        .clk        (clk),
        .rst        (rst),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .res_valid  (res_valid),
        .res_pc     (res_pc),
        .res_hist   (res_hist),
        .res_taken  (res_taken)
    );

    function automatic int slot(input logic [31:0] pc, input int h);
        return int'((pc >> 2) & 32'hF) * 4 + h;
    endfunction

    function automatic bit model_pred(input logic [31:0] pc);
        return model_ctr[slot(pc, model_hist)] >= 2;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 64; i++) model_ctr[i] = 1;
        model_hist = 0;
    endfunction

    function automatic void model_resolve(input logic [31:0] pc, input int h, input bit t);
        int s;
        s = slot(pc, h);
        if (t && model_ctr[s] < 3) model_ctr[s]++;
        else if (!t && model_ctr[s] > 0) model_ctr[s]--;
        model_hist = ((model_hist << 1) | int'(t)) & 3;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Drive at the falling edge, check the combinational answer, then let the rising edge update.
    task automatic step(input string req, input logic [31:0] ppc, input bit rv,
                        input logic [31:0] rpc, input int rh, input bit rt);
        @(negedge clk);
        pred_pc   = ppc;
        res_valid = rv;
        res_pc    = rpc;
        res_hist  = rh[1:0];
        res_taken = rt;
        #1;
        check(req, int'(pred_taken), int'(model_pred(ppc)));
        check(req, int'(pred_hist), model_hist);
        if (rv) model_resolve(rpc, rh, rt);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd20240611));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every row predicts not taken, history zero.
        for (int r = 0; r < 16; r++) begin
            step("R1", 32'(r) << 2, 1'b0, '0, 0, 1'b0);
            check("R1", int'(pred_taken), 0);
        end

        // R6 R7: drive row 3 / history 0 to saturation and back.
        a = 32'h0000_000C;
        for (int i = 0; i < 4; i++) step("R6", a, 1'b1, a, 0, 1'b1);
        for (int i = 0; i < 2; i++) step("R7", a, 1'b1, a, 0, 1'b0);
        // Counter is 01 now; bring history back to 0 and read it.
        step("R7", a, 1'b1, 32'h0000_0010, 1, 1'b0);
        step("R7", a, 1'b1, 32'h0000_0010, 1, 1'b0);
        step("R7", a, 1'b0, '0, 0, 1'b0);
        check("R7", int'(pred_taken), 0);

        // R8 R5: train row 5 under history 2 while live history differs.
        a = 32'h0000_0014;
        step("R8", a, 1'b1, a, 2, 1'b1);
        step("R8", a, 1'b1, a, 2, 1'b1);
        // Live history is 11: row 5 col 3 untouched, predicts not taken.
        step("R5", a, 1'b0, '0, 0, 1'b0);
        check("R5", int'(pred_taken), 0);
        // Move history to 10 and read the trained counter.
        step("R8", a, 1'b1, 32'h0000_0020, 3, 1'b0);
        step("R8", a, 1'b0, '0, 0, 1'b0);
        check("R8", int'(pred_hist), 2);
        check("R8", int'(pred_taken), 1);

        // R10: same row with scrambled unrelated bits reads the same counter.
        step("R10", 32'hFFFF_FF97, 1'b0, '0, 0, 1'b0);
        check("R10", int'(pred_taken), 1);

        // R9: idle cycles keep everything.
        for (int i = 0; i < 5; i++) step("R9", a, 1'b0, a, 2, 1'b0);
        check("R9", int'(pred_taken), 1);

        // R4: history sequence T, NT, T -> 01.
        step("R4", a, 1'b1, 32'h100, 0, 1'b1);
        step("R4", a, 1'b1, 32'h104, 1, 1'b0);
        step("R4", a, 1'b1, 32'h108, 2, 1'b1);
        step("R4", a, 1'b0, '0, 0, 1'b0);
        check("R4", int'(pred_hist), 1);

        // R2 R3 R10: random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] pp, rp;
            int rh;
            bit rv, rt;
            pp = $urandom();
            rp = ($urandom_range(0, 3) == 0) ? pp : $urandom();
            rv = ($urandom_range(0, 9) != 0);
            rt = ($urandom_range(0, 99) < ((rp[2]) ? 80 : 25));
            rh = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : model_hist;
            step("R2", pp, rv, rp, rh, rt);
        end

        finish_run();
    end

endmodule